// File: doc/BRIEF.md
# Parity-Predicted SEC/DED Guarded Adder

This block is a combinational ripple-carry adder whose result is guarded by a single-error-correcting, double-error-detecting Hamming check. The check bits are not computed from the adder's own output. A separate predictor works from the same operands and carry-in, and it produces the check bits and the overall parity that a fault-free sum would carry. A syndrome checker then joins the sum the adder actually produced with the predicted bits to form one codeword. It repairs a single corrupted bit, or it raises a double-error flag and leaves the sum untouched.

The operand width is a parameter. The number of check bits is derived from the smallest k that satisfies 2^k >= n + k + 1, where n is the sum width. At the default width of 3 this gives three check bits plus one overall parity bit for a 4-bit sum. Two XOR mask inputs can flip any sum bit or any predicted parity bit. These masks exist so that transient upsets can be emulated in verification. In normal use they are held at zero.

Top module: `hsa_guarded_adder`

## Requirements
- R1: With both flip masks zero, `sum_o` equals a_i + b_i + cin_i as a 4-bit value, and both error flags are 0.
- R2: Codeword positions 1 to 8 hold k1, k2, s3, k3, s2, s1, s0, P. The check bits are k1 = s3^s2^s0, k2 = s3^s1^s0 and k3 = s2^s1^s0, and P makes the whole word even. Bit i of `sum_flip_i` flips s_i. Bits 0, 1 and 2 of `chk_flip_i` flip k1, k2 and k3, and bit 3 flips P.
- R3: A single flipped sum bit is repaired, so `sum_o` shows the true sum, `single_err_o` is 1 and `double_err_o` is 0.
- R4: A single flipped check bit (k1, k2 or k3) leaves `sum_o` at the true sum, with `single_err_o` at 1 and `double_err_o` at 0.
- R5: A flip of P alone gives a zero syndrome with an overall parity mismatch. `sum_o` stays at the true sum, `single_err_o` is 1 and `double_err_o` is 0.
- R6: Any two flipped codeword bits set `double_err_o` to 1 and `single_err_o` to 0, and `sum_o` then shows the true sum XOR `sum_flip_i`, with no correction applied.
- R7: `single_err_o` and `double_err_o` are never 1 together.
- R8: With a=101, b=100 and carry-in 1, the sum is 1010. If s1 is forced to 0, the output is still 1010 and the single-error flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | OPW (3) | First operand |
| b_i | input | OPW (3) | Second operand |
| cin_i | input | 1 | Carry-in |
| sum_flip_i | input | OPW+1 (4) | XOR mask applied to the adder's sum bits |
| chk_flip_i | input | NCHK+1 (4) | XOR mask applied to predicted k1..k3 (bits 0-2) and P (bit 3) |
| sum_o | output | OPW+1 (4) | Corrected or passed-through sum |
| single_err_o | output | 1 | A single-bit codeword error was seen |
| double_err_o | output | 1 | A double-bit codeword error was seen |

## Verification
Each result is due in the same cycle as its stimulus. The path from the inputs to `sum_o` and both flags holds no register, so the latency is zero cycles. The bench applies each operand and mask set just after a rising edge and compares it at the next falling edge, half a period later. This keeps exactly one item in flight between the driver and the monitor. Every operand and carry combination is swept with no flip, with each of the eight single flips, and with each of the 28 flip pairs.

// File: rtl/hsa_pkg.sv
package hsa_pkg;

   // Smallest k with 2^k >= n + k + 1
   function automatic int calc_nchk(input int n);
      int k;
      k = 1;
      while ((1 << k) < n + k + 1) k++;
      return k;
   endfunction

   function automatic bit is_pow2(input int p);
      return (p & (p - 1)) == 0;
   endfunction

   // Codeword position (1-based) of the d-th data bit; d = 0 is the sum MSB
   function automatic int data_pos(input int d);
      int p;
      int cnt;
      p   = 0;
      cnt = -1;
      while (cnt < d) begin
         p++;
         if (!is_pow2(p)) cnt++;
      end
      return p;
   endfunction

endpackage

// File: rtl/hsa_ripple_adder.sv
module hsa_ripple_adder #(
   parameter int OPW = 3
) (
   input  logic [OPW-1:0] a_i,
   input  logic [OPW-1:0] b_i,
   input  logic           cin_i,
   output logic [OPW:0]   sum_o
);
   logic [OPW:0] carry;

   assign carry[0] = cin_i;

   for (genvar i = 0; i < OPW; i++) begin : g_fa
      assign sum_o[i]     = a_i[i] ^ b_i[i] ^ carry[i];
      assign carry[i + 1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
   end

   assign sum_o[OPW] = carry[OPW];
endmodule

// File: rtl/hsa_parity_predictor.sv
module hsa_parity_predictor
   import hsa_pkg::*;
#(
   parameter int OPW  = 3,
   parameter int NCHK = 3
) (
   input  logic [OPW-1:0]  a_i,
   input  logic [OPW-1:0]  b_i,
   input  logic            cin_i,
   output logic [NCHK-1:0] chk_o,
   output logic            ovp_o
);
   localparam int SUMW = OPW + 1;

   // Independent formulation of the expected sum, not the ripple chain
   logic [SUMW-1:0] exp_sum;
   assign exp_sum = SUMW'(a_i) + SUMW'(b_i) + SUMW'(cin_i);

   always_comb begin
      chk_o = '0;
      for (int j = 0; j < NCHK; j++) begin
         for (int d = 0; d < SUMW; d++) begin
            if (((data_pos(d) >> j) & 1) != 0)
               chk_o[j] = chk_o[j] ^ exp_sum[SUMW-1-d];
         end
      end
      ovp_o = (^exp_sum) ^ (^chk_o);
   end
endmodule

// File: rtl/hsa_syndrome_checker.sv
module hsa_syndrome_checker
   import hsa_pkg::*;
#(
   parameter int SUMW = 4,
   parameter int NCHK = 3
) (
   input  logic [SUMW-1:0] sum_i,
   input  logic [NCHK-1:0] chk_i,
   input  logic            ovp_i,
   output logic [SUMW-1:0] sum_o,
   output logic            single_o,
   output logic            double_o
);
   localparam int NPOS = SUMW + NCHK;

   logic [NCHK-1:0] syn;
   logic            ovp_mis;
   logic            pos_ok;

   always_comb begin
      syn = chk_i;
      for (int j = 0; j < NCHK; j++) begin
         for (int d = 0; d < SUMW; d++) begin
            if (((data_pos(d) >> j) & 1) != 0)
               syn[j] = syn[j] ^ sum_i[SUMW-1-d];
         end
      end
      ovp_mis  = (^sum_i) ^ (^chk_i) ^ ovp_i;
      pos_ok   = int'(syn) <= NPOS;
      single_o = ovp_mis && ((syn == '0) || pos_ok);
      double_o = (syn != '0) && (!ovp_mis || !pos_ok);
      for (int d = 0; d < SUMW; d++) begin
         sum_o[SUMW-1-d] = sum_i[SUMW-1-d]
                         ^ (single_o && (int'(syn) == data_pos(d)));
      end
   end
endmodule

// File: rtl/hsa_guarded_adder.sv
module hsa_guarded_adder
   import hsa_pkg::*;
#(
   parameter int OPW = 3
) (
   input  logic [OPW-1:0]            a_i,
   input  logic [OPW-1:0]            b_i,
   input  logic                      cin_i,
   input  logic [OPW:0]              sum_flip_i,
   input  logic [calc_nchk(OPW+1):0] chk_flip_i,
   output logic [OPW:0]              sum_o,
   output logic                      single_err_o,
   output logic                      double_err_o
);
   localparam int SUMW = OPW + 1;
   localparam int NCHK = calc_nchk(SUMW);

   if (OPW < 1 || OPW > 16) begin : g_bad_width
      $error("hsa_guarded_adder: OPW out of range");
   end

   logic [SUMW-1:0] add_sum;
   logic [SUMW-1:0] add_sum_f;
   logic [NCHK-1:0] pred_chk;
   logic [NCHK-1:0] pred_chk_f;
   logic            pred_ovp;
   logic            pred_ovp_f;

   hsa_ripple_adder #(.OPW(OPW)) u_add (
      .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .sum_o(add_sum)
   );

   hsa_parity_predictor #(.OPW(OPW), .NCHK(NCHK)) u_pred (
      .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .chk_o(pred_chk), .ovp_o(pred_ovp)
   );

   assign add_sum_f  = add_sum ^ sum_flip_i;
   assign pred_chk_f = pred_chk ^ chk_flip_i[NCHK-1:0];
   assign pred_ovp_f = pred_ovp ^ chk_flip_i[NCHK];

   hsa_syndrome_checker #(.SUMW(SUMW), .NCHK(NCHK)) u_chk (
      .sum_i(add_sum_f), .chk_i(pred_chk_f), .ovp_i(pred_ovp_f),
      .sum_o(sum_o), .single_o(single_err_o), .double_o(double_err_o)
   );
endmodule

// File: rtl/hsa_guarded_adder_chk.sv
module hsa_guarded_adder_chk
   import hsa_pkg::*;
#(
   parameter int OPW = 3
) (
   input logic [OPW-1:0]            a_i,
   input logic [OPW-1:0]            b_i,
   input logic                      cin_i,
   input logic [OPW:0]              sum_flip_i,
   input logic [calc_nchk(OPW+1):0] chk_flip_i,
   input logic [OPW:0]              sum_o,
   input logic                      single_err_o,
   input logic                      double_err_o
);
   localparam int SUMW = OPW + 1;

   logic [SUMW-1:0] true_sum;
   int              nflip;

   always_comb begin
      true_sum = SUMW'(a_i) + SUMW'(b_i) + SUMW'(cin_i);
      nflip    = $countones({sum_flip_i, chk_flip_i});

      // R1
      clean_sum_chk: assert (nflip != 0 ||
                             (sum_o == true_sum && !single_err_o && !double_err_o))
         else $error("clean path wrong");
      // R3
      single_fix_chk: assert (nflip != 1 ||
                              (sum_o == true_sum && single_err_o && !double_err_o))
         else $error("single flip not repaired");
      // R6
      double_flag_chk: assert (nflip != 2 ||
                               (double_err_o && !single_err_o &&
                                sum_o == (true_sum ^ sum_flip_i)))
         else $error("double flip not flagged");
      // R7
      flag_excl_chk: assert ($onehot0({single_err_o, double_err_o}))
         else $error("both flags high");
   end
endmodule

bind hsa_guarded_adder hsa_guarded_adder_chk #(.OPW(OPW)) u_hsa_chk (
   .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
   .sum_flip_i(sum_flip_i), .chk_flip_i(chk_flip_i),
   .sum_o(sum_o), .single_err_o(single_err_o), .double_err_o(double_err_o)
);

// File: tb/hsa_guarded_adder_tb_top.sv
module hsa_guarded_adder_tb_top;
   logic       clk = 1'b0;
   logic [2:0] a, b;
   logic       cin;
   logic [3:0] sflip, cflip;
   logic [3:0] sum;
   logic       sgl, dbl;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  drv_done = 1'b0;

   typedef struct {
      logic [3:0] sum;
      logic       sgl;
      logic       dbl;
      string      req;
   } exp_t;
   exp_t sb_q[$];

   always #10 clk = ~clk;   // 50 MHz

   hsa_guarded_adder dut_i (
      .a_i(a), .b_i(b), .cin_i(cin), .sum_flip_i(sflip), .chk_flip_i(cflip),
      .sum_o(sum), .single_err_o(sgl), .double_err_o(dbl)
   );

   task automatic drive(input logic [2:0] ta, input logic [2:0] tb,
                        input logic tc, input logic [7:0] flips);
      exp_t e;
      logic [3:0] ts;
      int n;
      @(posedge clk);
      #1;
      a = ta; b = tb; cin = tc;
      sflip = flips[3:0]; cflip = flips[7:4];
      ts = 4'(ta) + 4'(tb) + 4'(tc);
      n  = $countones(flips);
      if (n == 0)      begin e.sum = ts; e.sgl = 0; e.dbl = 0; e.req = "R1"; end
      else if (n == 1) begin
         e.sum = ts; e.sgl = 1; e.dbl = 0;
         if (flips[3:0] != 0)  e.req = "R2,R3";
         else if (flips[7])    e.req = "R5";
         else                  e.req = "R2,R4";
      end
      else begin e.sum = ts ^ flips[3:0]; e.sgl = 0; e.dbl = 1; e.req = "R6"; end
      sb_q.push_back(e);
   endtask

   task automatic drive_named(input logic [2:0] ta, input logic [2:0] tb,
                              input logic tc, input logic [7:0] flips,
                              input string tag);
      drive(ta, tb, tc, flips);
      sb_q[sb_q.size()-1].req = tag;
   endtask

   // monitor: samples on falling edge
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         n_run++;
         if (sum !== e.sum || sgl !== e.sgl || dbl !== e.dbl) begin
            n_fail++;
            $display("FAIL %s: a=%b b=%b cin=%b sf=%b cf=%b got sum=%b s=%b d=%b exp sum=%b s=%b d=%b",
                     e.req, a, b, cin, sflip, cflip, sum, sgl, dbl, e.sum, e.sgl, e.dbl);
         end
         n_run++;
         if (sgl === 1'b1 && dbl === 1'b1) begin   // R7
            n_fail++;
            $display("FAIL R7: got sgl=%b dbl=%b exp not both 1", sgl, dbl);
         end
      end
   end

   initial begin
      a = '0; b = '0; cin = 1'b0; sflip = '0; cflip = '0;
      repeat (2) @(posedge clk);
      // idle state, all zero (R1)
      drive_named(3'b000, 3'b000, 1'b0, 8'h00, "R1");
      // worked example: clean and s1 forced low (R8)
      drive_named(3'b101, 3'b100, 1'b1, 8'h00, "R8");
      drive_named(3'b101, 3'b100, 1'b1, 8'h02, "R8");
      for (int v = 0; v < 128; v++) begin
         logic [2:0] ta, tb;
         logic tc;
         ta = v[2:0]; tb = v[5:3]; tc = v[6];
         drive(ta, tb, tc, 8'h00);
         for (int i = 0; i < 8; i++) drive(ta, tb, tc, 8'(1 << i));
         for (int i = 0; i < 8; i++)
            for (int j = i + 1; j < 8; j++)
               drive(ta, tb, tc, 8'((1 << i) | (1 << j)));
      end
      repeat (3) @(posedge clk);
      drv_done = 1'b1;
   end

   initial begin
      fork
         wait (drv_done);
         begin
            #(20 * 200000);
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule